// File: doc/BRIEF.md
# Lane-Preserving Dynamic Warp Compactor

After a data-dependent branch, each warp of a small batch splits into two disjoint sets of threads, one per branch target. Run unchanged, every such half-warp costs a full issue slot. This block takes in a batch of diverged warps and reissues their threads in packed groups. A packed group holds threads from different warps that wait at the same program counter. No thread ever leaves the lane position it had in its home warp. So a lane that no waiting thread can fill stays empty, and each lane of a packed group carries the ID of the warp that owns its thread. The result can then be written back to the correct context.

A batch is loaded in one handshake. For every warp it gives a lane mask and a target PC for each branch side, which here are called side A and side B. The block then goes through three states. `ST_IDLE` accepts a batch. `ST_PICK` chooses the next PC that still has pending threads, and returns to `ST_IDLE` when none is left. `ST_EMIT` presents packed groups at that PC on a valid/ready output. The transitions are:
- load: `ST_IDLE`→`ST_PICK`, on an accepted batch.
- found: `ST_PICK`→`ST_EMIT`, when a pending PC exists.
- drained: `ST_PICK`→`ST_IDLE`, when no pending PC exists.
- next-PC: `ST_EMIT`→`ST_PICK`, when the accepted group was the last one at the current PC.
- hold: `ST_EMIT`→`ST_EMIT`, on a stall, or when threads still wait at the current PC.

Top module: `dwc_top`

## Requirements
- R1: During and after reset, `out_valid` is 0 and `in_ready` is 1.
- R2: `in_ready` is 1 only while no batch is being processed. A batch is taken when `in_valid` and `in_ready` are both 1. While a batch is being processed, `in_valid` and the batch inputs have no effect on the output sequence.
- R3: Every active thread of an accepted batch is issued in exactly one accepted output group, and no other thread is issued. Warp w side A uses mask bits `[w*LANES +: LANES]` and PC bits `[w*PC_W +: PC_W]`, and side B uses the same positions in its own ports. Bit i of a mask is lane i. The two side masks of a warp are disjoint.
- R4: A thread from lane i of warp w appears only in output lane i, with `out_wid[i*WID_W +: WID_W]` equal to w.
- R5: While `out_valid` is 1, `out_mask` is never zero.
- R6: Packing is greedy. In each group, lane i holds the thread of the lowest-numbered warp that still has an unissued thread in lane i at the current PC. The block keeps issuing groups at that PC until none remain.
- R7: PCs are served in the order of the first pending entry. Entries are scanned by warp number ascending, with side A before side B in each warp. All groups for one PC are issued consecutively.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_pc`, `out_mask` and `out_wid` hold their values.
- R9: For every lane that is 0 in `out_mask`, the `out_wid` field reads 0.
- R10: A batch with all masks zero produces no output, and `in_ready` is 1 again two clock edges after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Batch offered |
| in_ready | output | 1 | Block idle, batch can be taken |
| in_mask_a | input | WARPS*LANES | Side A lane mask for each warp |
| in_pc_a | input | WARPS*PC_W | Side A PC for each warp |
| in_mask_b | input | WARPS*LANES | Side B lane mask for each warp |
| in_pc_b | input | WARPS*PC_W | Side B PC for each warp |
| out_valid | output | 1 | Packed group present |
| out_ready | input | 1 | Consumer accepts group |
| out_pc | output | PC_W | PC of the packed group |
| out_mask | output | LANES | Occupied lanes |
| out_wid | output | LANES*WID_W | Home warp of each lane |

## Verification
The assertions assume that the two side masks of each loaded warp do not overlap, as a real branch split guarantees. This assumption is itself checked when a batch is accepted. They also assume that the consumer may stall at any cycle. The stimulus vectors are built so that every warp's A and B masks are disjoint. The ready pattern holds `out_ready` low on a regular subset of cycles, so that groups are stalled mid-PC as well as at the end of a PC. One vector keeps `in_valid` raised with unrelated data during processing, to show that a busy block ignores it.

// File: rtl/dwc_pkg.sv
package dwc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PICK = 2'd1,
        ST_EMIT = 2'd2
    } dwc_state_e;
endpackage

// File: rtl/dwc_pc_select.sv
module dwc_pc_select #(
    parameter int ENTRIES = 8,
    parameter int LANES   = 4,
    parameter int PC_W    = 16
) (
    input  logic [ENTRIES*LANES-1:0] ent_mask,
    input  logic [ENTRIES*PC_W-1:0]  ent_pc,
    output logic                     sel_any,
    output logic [PC_W-1:0]          sel_pc
);
    logic [ENTRIES-1:0] live;

    genvar e;
    generate
        for (e = 0; e < ENTRIES; e++) begin : g_live
            assign live[e] = |ent_mask[e*LANES +: LANES];
        end
    endgenerate

    // lowest entry index wins: scan downward and overwrite
    always_comb begin
        sel_any = 1'b0;
        sel_pc  = '0;
        for (int k = ENTRIES - 1; k >= 0; k--) begin
            if (live[k]) begin
                sel_any = 1'b1;
                sel_pc  = ent_pc[k*PC_W +: PC_W];
            end
        end
    end
endmodule

// File: rtl/dwc_lane_pack.sv
module dwc_lane_pack #(
    parameter int ENTRIES = 8,
    parameter int LANES   = 4,
    parameter int PC_W    = 16,
    parameter int WID_W   = 2
) (
    input  logic [ENTRIES*LANES-1:0] ent_mask,
    input  logic [ENTRIES*PC_W-1:0]  ent_pc,
    input  logic [PC_W-1:0]          cur_pc,
    output logic [LANES-1:0]         pk_mask,
    output logic [LANES*WID_W-1:0]   pk_wid,
    output logic [ENTRIES*LANES-1:0] grant,
    output logic                     more
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] pc_hit;
    logic [LANES-1:0]   lane_hit;
    logic [IDX_W-1:0]   lane_idx [LANES];

    genvar e, l;
    generate
        for (e = 0; e < ENTRIES; e++) begin : g_match
            assign pc_hit[e] = (ent_pc[e*PC_W +: PC_W] == cur_pc);
        end

        for (l = 0; l < LANES; l++) begin : g_lane
            // lowest entry (hence lowest warp) pending at cur_pc in lane l
            always_comb begin
                lane_hit[l] = 1'b0;
                lane_idx[l] = '0;
                for (int k = ENTRIES - 1; k >= 0; k--) begin
                    if (pc_hit[k] && ent_mask[k*LANES + l]) begin
                        lane_hit[l] = 1'b1;
                        lane_idx[l] = IDX_W'(k);
                    end
                end
            end
            assign pk_mask[l] = lane_hit[l];
            assign pk_wid[l*WID_W +: WID_W] =
                lane_hit[l] ? WID_W'(lane_idx[l] >> 1) : '0;

            for (e = 0; e < ENTRIES; e++) begin : g_grant
                assign grant[e*LANES + l] = lane_hit[l] && (lane_idx[l] == IDX_W'(e));
            end
        end
    endgenerate

    // threads still waiting at cur_pc once this group is taken
    always_comb begin
        more = 1'b0;
        for (int k = 0; k < ENTRIES; k++) begin
            if (pc_hit[k] && |(ent_mask[k*LANES +: LANES] & ~grant[k*LANES +: LANES]))
                more = 1'b1;
        end
    end
endmodule

// File: rtl/dwc_top.sv
module dwc_top #(
    parameter int WARPS = 4,
    parameter int LANES = 4,
    parameter int PC_W  = 16,
    parameter int WID_W = (WARPS > 1) ? $clog2(WARPS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [WARPS*LANES-1:0] in_mask_a,
    input  logic [WARPS*PC_W-1:0]  in_pc_a,
    input  logic [WARPS*LANES-1:0] in_mask_b,
    input  logic [WARPS*PC_W-1:0]  in_pc_b,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [PC_W-1:0]        out_pc,
    output logic [LANES-1:0]       out_mask,
    output logic [LANES*WID_W-1:0] out_wid
);
    import dwc_pkg::*;

    localparam int ENTRIES = 2 * WARPS;

    dwc_state_e state_q, state_d;

    logic [ENTRIES*LANES-1:0] ent_mask_q;
    logic [ENTRIES*PC_W-1:0]  ent_pc_q;
    logic [PC_W-1:0]          cur_pc_q;

    logic                     sel_any;
    logic [PC_W-1:0]          sel_pc;
    logic [LANES-1:0]         pk_mask;
    logic [LANES*WID_W-1:0]   pk_wid;
    logic [ENTRIES*LANES-1:0] grant;
    logic                     more;
    logic                     accept;
    logic                     fire;

    dwc_pc_select #(.ENTRIES(ENTRIES), .LANES(LANES), .PC_W(PC_W)) u_sel (
        .ent_mask (ent_mask_q),
        .ent_pc   (ent_pc_q),
        .sel_any  (sel_any),
        .sel_pc   (sel_pc)
    );

    dwc_lane_pack #(.ENTRIES(ENTRIES), .LANES(LANES), .PC_W(PC_W), .WID_W(WID_W)) u_pack (
        .ent_mask (ent_mask_q),
        .ent_pc   (ent_pc_q),
        .cur_pc   (cur_pc_q),
        .pk_mask  (pk_mask),
        .pk_wid   (pk_wid),
        .grant    (grant),
        .more     (more)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept)          state_d = ST_PICK;
            ST_PICK: state_d = sel_any ? ST_EMIT : ST_IDLE;
            ST_EMIT: if (fire && !more)   state_d = ST_PICK;
            default:                      state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_pc    = '0;
        out_mask  = '0;
        out_wid   = '0;
        unique case (state_q)
            ST_IDLE: in_ready = 1'b1;
            ST_PICK: ;
            ST_EMIT: begin
                out_valid = 1'b1;
                out_pc    = cur_pc_q;
                out_mask  = pk_mask;
                out_wid   = pk_wid;
            end
            default: ;
        endcase
    end

    assign accept = in_valid && in_ready;
    assign fire   = out_valid && out_ready;

    // pending thread store: entry 2w is side A of warp w, 2w+1 side B
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_mask_q <= '0;
            ent_pc_q   <= '0;
            cur_pc_q   <= '0;
        end else begin
            if (accept) begin
                for (int w = 0; w < WARPS; w++) begin
                    ent_mask_q[(2*w)*LANES +: LANES]   <= in_mask_a[w*LANES +: LANES];
                    ent_mask_q[(2*w+1)*LANES +: LANES] <= in_mask_b[w*LANES +: LANES];
                    ent_pc_q[(2*w)*PC_W +: PC_W]       <= in_pc_a[w*PC_W +: PC_W];
                    ent_pc_q[(2*w+1)*PC_W +: PC_W]     <= in_pc_b[w*PC_W +: PC_W];
                end
            end else if (fire) begin
                ent_mask_q <= ent_mask_q & ~grant;
            end
            if (state_q == ST_PICK && sel_any)
                cur_pc_q <= sel_pc;
        end
    end

    // lanes that hold any pending thread, formed apart from the packer
    logic [LANES-1:0] lane_pending;
    always_comb begin
        lane_pending = '0;
        for (int k = 0; k < ENTRIES; k++)
            lane_pending = lane_pending | ent_mask_q[k*LANES +: LANES];
    end

    assert_in_disjoint_R3: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> ((in_mask_a & in_mask_b) == '0));

    assert_issue_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> ($countones(ent_mask_q) + $countones($past(out_mask))
                  == $countones($past(ent_mask_q))));

    assert_lane_origin_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_mask & ~lane_pending) == '0));

    assert_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_mask != '0));

    assert_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !out_valid);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_pc) && $stable(out_mask) && $stable(out_wid)));
endmodule

// File: tb/tb_dwc_top.sv
module tb_dwc_top;
    localparam int W = 4, L = 4, PW = 16, WW = 2, NV = 5;

    // stimulus vectors: masks bit (w*4+i) = warp w lane i; PCs 16 bits per warp
    localparam logic [15:0] TV_MA [NV] = '{16'h0F53, 16'hFFFF, 16'hC3C3, 16'h0081, 16'h0000};
    localparam logic [15:0] TV_MB [NV] = '{16'h00AC, 16'h0000, 16'h3C3C, 16'h007E, 16'h0000};
    localparam logic [63:0] TV_PA [NV] = '{64'h0000_0010_0010_0010, 64'h0005_0005_0005_0005,
                                           64'h0007_0009_0007_0007, 64'h0000_0000_0004_0003,
                                           64'h0000_0000_0000_0000};
    localparam logic [63:0] TV_PB [NV] = '{64'h0000_0000_0020_0020, 64'h0000_0000_0000_0000,
                                           64'h0009_0007_0009_0009, 64'h0000_0000_0003_0003,
                                           64'h0000_0000_0000_0000};

    logic clk = 0, rst_n = 0;
    logic in_valid = 0, in_ready, out_valid, out_ready = 0;
    logic [15:0] in_mask_a = 0, in_mask_b = 0, m_a, m_b;
    logic [63:0] in_pc_a = 0, in_pc_b = 0, p_a, p_b;
    logic [PW-1:0] out_pc;
    logic [L-1:0] out_mask;
    logic [L*WW-1:0] out_wid;

    int tests = 0, fails = 0;
    int exp_n;
    logic [PW-1:0] e_pc [32];
    logic [L-1:0]  e_mask [32];
    logic [L*WW-1:0] e_wid [32];
    int issued [W][L];

    always #4 clk = ~clk;

    dwc_top #(.WARPS(W), .LANES(L), .PC_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_mask_a(in_mask_a), .in_pc_a(in_pc_a), .in_mask_b(in_mask_b), .in_pc_b(in_pc_b),
        .out_valid(out_valid), .out_ready(out_ready), .out_pc(out_pc),
        .out_mask(out_mask), .out_wid(out_wid));

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // expected group list from the greedy rules R6/R7
    task automatic model();
        logic [15:0] ra = m_a, rb = m_b;
        exp_n = 0;
        forever begin
            bit any = 0;
            logic [PW-1:0] pc = 0;
            for (int e = 2*W-1; e >= 0; e--) begin
                logic [3:0] m = (e%2==0) ? ra[(e/2)*4 +: 4] : rb[(e/2)*4 +: 4];
                if (m != 0) begin any = 1; pc = (e%2==0) ? p_a[(e/2)*16 +: 16] : p_b[(e/2)*16 +: 16]; end
            end
            if (!any) break;
            forever begin
                logic [L-1:0] gm = 0;
                logic [L*WW-1:0] gw = 0;
                for (int i = 0; i < L; i++) begin
                    for (int w = 0; w < W && !gm[i]; w++) begin
                        if (ra[w*4+i] && p_a[w*16 +: 16] == pc) begin gm[i] = 1; gw[i*WW +: WW] = WW'(w); ra[w*4+i] = 0; end
                        else if (rb[w*4+i] && p_b[w*16 +: 16] == pc) begin gm[i] = 1; gw[i*WW +: WW] = WW'(w); rb[w*4+i] = 0; end
                    end
                end
                if (gm == 0) break;
                e_pc[exp_n] = pc; e_mask[exp_n] = gm; e_wid[exp_n] = gw; exp_n++;
            end
        end
    endtask

    task automatic run_vec(input int v, input bit junk);
        int got = 0, guard = 0;
        bit stalled = 0;
        logic [PW-1:0] s_pc; logic [L-1:0] s_m; logic [L*WW-1:0] s_w;
        m_a = TV_MA[v]; m_b = TV_MB[v]; p_a = TV_PA[v]; p_b = TV_PB[v];
        model();
        for (int w = 0; w < W; w++) for (int i = 0; i < L; i++) issued[w][i] = 0;
        @(negedge clk);
        chk(in_ready == 1, "R2 idle before load", 64'(in_ready), 1);
        in_valid = 1; in_mask_a = m_a; in_mask_b = m_b; in_pc_a = p_a; in_pc_b = p_b;
        @(negedge clk);
        in_valid = junk;
        if (junk) begin in_mask_a = 16'hFFFF; in_mask_b = 0; in_pc_a = {4{16'h0777}}; end
        while (got < exp_n && guard < 400) begin
            if (guard == 3) in_valid = 0;
            if (stalled) chk(out_valid && out_pc == s_pc && out_mask == s_m && out_wid == s_w,
                             "R8 hold on stall", {out_pc, out_mask, out_wid}, {s_pc, s_m, s_w});
            stalled = 0;
            out_ready = ((guard % 3) != 1);
            if (out_valid) begin
                if (out_ready) begin
                    chk(out_mask != 0, "R5 nonempty", 64'(out_mask), 64'hF);
                    chk(out_pc == e_pc[got], "R7 pc order", 64'(out_pc), 64'(e_pc[got]));
                    chk(out_mask == e_mask[got] && out_wid == e_wid[got], "R6 greedy pack",
                        {out_mask, out_wid}, {e_mask[got], e_wid[got]});
                    for (int i = 0; i < L; i++) begin
                        int w = int'(out_wid[i*WW +: WW]);
                        if (out_mask[i]) begin
                            issued[w][i]++;
                            chk((m_a[w*4+i] && p_a[w*16 +: 16] == out_pc) || (m_b[w*4+i] && p_b[w*16 +: 16] == out_pc),
                                "R4 lane kept", 64'(w*4+i), 64'(out_pc));
                        end else chk(out_wid[i*WW +: WW] == 0, "R9 idle lane wid", 64'(out_wid[i*WW +: WW]), 0);
                    end
                    got++;
                end else begin
                    stalled = 1; s_pc = out_pc; s_m = out_mask; s_w = out_wid;
                end
            end
            guard++;
            @(negedge clk);
        end
        out_ready = 1;
        for (int k = 0; k < 6 && !in_ready; k++) begin
            chk(!out_valid, "R3 no extra group", 64'(out_valid), 0);
            @(negedge clk);
        end
        chk(in_ready == 1 && got == exp_n, "R3 batch drained", 64'(got), 64'(exp_n));
        for (int w = 0; w < W; w++) for (int i = 0; i < L; i++)
            chk(issued[w][i] == int'(m_a[w*4+i] | m_b[w*4+i]), "R3 exactly once",
                64'(issued[w][i]), 64'(m_a[w*4+i] | m_b[w*4+i]));
        if (junk) chk(!out_valid, "R2 busy input ignored", 64'(out_valid), 0);
    endtask

    initial begin : wdog
        repeat (100000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(out_valid == 0 && in_ready == 1, "R1 in reset", {out_valid, in_ready}, 2'b01);
        rst_n = 1;
        @(negedge clk);
        chk(out_valid == 0 && in_ready == 1, "R1 after reset", {out_valid, in_ready}, 2'b01);
        for (int v = 0; v < NV - 1; v++) run_vec(v, v == 1);
        // R10: all-zero batch
        @(negedge clk);
        in_valid = 1; in_mask_a = 0; in_mask_b = 0;
        @(negedge clk);
        in_valid = 0;
        chk(!out_valid && !in_ready, "R10 one edge after load", {out_valid, in_ready}, 2'b00);
        @(negedge clk);
        chk(!out_valid && in_ready, "R10 idle two edges after load", {out_valid, in_ready}, 2'b01);
        // R1: reset in mid-batch clears state
        m_a = TV_MA[0];
        in_valid = 1; in_mask_a = m_a; in_mask_b = TV_MB[0]; in_pc_a = TV_PA[0]; in_pc_b = TV_PB[0];
        @(negedge clk); in_valid = 0; out_ready = 0;
        repeat (3) @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(out_valid == 0 && in_ready == 1, "R1 reset mid-batch", {out_valid, in_ready}, 2'b01);
        run_vec(2, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule